// File: doc/BRIEF.md
# Vector Bitwise Merge Execution Unit

This unit executes one class of vector instructions: the four bitwise merge operations. They are exclusive OR, select-by-mask, insert-where-mask-set and insert-where-mask-clear. A 32-bit instruction word is presented with a valid/ready handshake. The unit decodes it and reads up to three entries of its internal 32-entry vector register file. These are the two sources and the current destination value. It evaluates the operation and writes the result back to the destination at the next clock edge. A result-valid pulse goes out at the same time, carrying the destination index and the written data.

All four operations share a single merged expression: `p ^ ((q ^ n) & k)`. Only the routing of the source values, or of the old destination value, into `p`, `q` and `k` differs between them. The width bit selects either a half-width operation or a full-width operation. A half-width operation uses the low 8 byte lanes and clears the upper half of the destination. A full-width operation uses all 16 byte lanes. If any fixed bit of the instruction word is wrong, the unit raises an illegal pulse instead and writes nothing. A debug read port lets surrounding logic or a bench observe any register.

Top module: `vbit_exec_unit`

## Requirements
- R1: An instruction is legal only when all of the following hold: bit 31 = 0, bits 29:24 = 6'b101110, bit 21 = 1 and bits 15:10 = 6'b000111. An accepted illegal word gives `illegal` = 1 for exactly the cycle after the accepting edge, with `wb_valid` = 0 and no register changed.
- R2: Selector bits 23:22 = 2'b00 write `Rd = Rn ^ Rm`. Here Rd is bits 4:0, Rn is bits 9:5 and Rm is bits 20:16.
- R3: Selector 2'b01 (select) writes `Rd = (Rn & oldRd) | (Rm & ~oldRd)`.
- R4: Selector 2'b10 (insert where mask set) writes `Rd = (Rn & Rm) | (oldRd & ~Rm)`.
- R5: Selector 2'b11 (insert where mask clear) writes `Rd = (Rn & ~Rm) | (oldRd & Rm)`.
- R6: When bit 30 = 0, only bits 63:0 are computed and bits 127:64 of the destination are written as zero. When bit 30 = 1, all 128 bits are computed.
- R7: `issue_ready` is always 1. For every legal accepted word, `wb_valid` is 1 in the following cycle, for one cycle, with `wb_dst`/`wb_data` equal to the destination index and the new value. The register reads back the new value from that cycle on, whatever the data.
- R8: After reset, register i holds, in byte lane b, the value (i*29 + b*7 + 3) mod 256. `wb_valid` and `illegal` are 0.
- R9: Operands are the register values before the accepting edge, even when Rd, Rn and Rm name the same register.
- R10: A cycle with `issue_valid` = 0 changes no register and gives `wb_valid` = 0 and `illegal` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word offered |
| issue_ready | output | 1 | Unit can accept (always 1) |
| issue_insn | input | 32 | Instruction word |
| wb_valid | output | 1 | One-cycle writeback pulse |
| wb_dst | output | 5 | Written register index |
| wb_data | output | 128 | Written value |
| illegal | output | 1 | One-cycle bad-encoding pulse |
| dbg_addr | input | 5 | Debug read index |
| dbg_data | output | 128 | Debug read value (combinational) |

## Verification
Every result of this unit is due exactly one clock after the accepting edge: the writeback pulse, the written data, the illegal pulse and the new register content on the debug port. The bench model consumes the handshake on the same rising edge as the design and queues its expectations. It compares them at the following falling edge, so each check lands in the single cycle where the result must appear. Register contents are swept through the debug port during idle stretches, with no issue in flight. This catches stray writes from illegal or idle cycles.

// File: rtl/vbit_pkg.sv
`timescale 1ns/1ps
package vbit_pkg;
   localparam int INSN_W = 32;
   localparam int RIDX_W = 5;
   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      BOP_XOR       = 2'b00,
      BOP_SELECT    = 2'b01,
      BOP_INS_TRUE  = 2'b10,
      BOP_INS_FALSE = 2'b11
   } bop_e;

   typedef struct packed {
      logic              legal;
      logic              wide;
      bop_e              op;
      logic [RIDX_W-1:0] dst;
      logic [RIDX_W-1:0] srcn;
      logic [RIDX_W-1:0] srcm;
   } bop_dec_t;
endpackage

// File: rtl/vbit_decode.sv
`timescale 1ns/1ps
module vbit_decode
   import vbit_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output bop_dec_t          dec
);
   localparam logic [5:0] MAJOR_PAT = 6'b101110;
   localparam logic [5:0] MINOR_PAT = 6'b000111;

   logic top_ok, major_ok, mid_ok, minor_ok;

   always_comb begin
      top_ok    = (insn[31] == 1'b0);
      major_ok  = (insn[29:24] == MAJOR_PAT);
      mid_ok    = (insn[21] == 1'b1);
      minor_ok  = (insn[15:10] == MINOR_PAT);
      dec.legal = top_ok && major_ok && mid_ok && minor_ok;
      dec.wide  = insn[30];
      dec.op    = bop_e'(insn[23:22]);
      dec.srcm  = insn[20:16];
      dec.srcn  = insn[9:5];
      dec.dst   = insn[4:0];
   end
endmodule

// File: rtl/vbit_regfile.sv
`timescale 1ns/1ps
module vbit_regfile
   import vbit_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int NREG   = 32,
   parameter int NRD    = 4
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NRD-1:0][RIDX_W-1:0]    raddr,
   output logic [NRD-1:0][DATA_W-1:0]    rdata,
   input  logic                          we,
   input  logic [RIDX_W-1:0]             waddr,
   input  logic [DATA_W-1:0]             wdata
);
   localparam int LANES = DATA_W / LANE_W;

   logic [DATA_W-1:0] mem [NREG];

   function automatic logic [DATA_W-1:0] seed_value(input int idx);
      logic [DATA_W-1:0] v;
      v = '0;
      for (int b = 0; b < LANES; b++) begin
         v[b*LANE_W +: LANE_W] = LANE_W'(idx * 29 + b * 7 + 3);
      end
      return v;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            mem[i] <= seed_value(i);
         end
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rport
      assign rdata[p] = mem[raddr[p]];
   end
endmodule

// File: rtl/vbit_datapath.sv
`timescale 1ns/1ps
module vbit_datapath
   import vbit_pkg::*;
#(
   parameter int DATA_W = 128
)(
   input  bop_e              op,
   input  logic              wide,
   input  logic [DATA_W-1:0] src_n,
   input  logic [DATA_W-1:0] src_m,
   input  logic [DATA_W-1:0] old_d,
   output logic [DATA_W-1:0] res
);
   localparam int LANES     = DATA_W / LANE_W;
   localparam int NARROW_LN = LANES / 2;

   logic [DATA_W-1:0] pass_v, cmp_v, mask_v;

   // operand routing: only this part depends on the opcode
   always_comb begin
      unique case (op)
         BOP_XOR: begin
            pass_v = src_m;
            cmp_v  = '0;
            mask_v = '1;
         end
         BOP_SELECT: begin
            pass_v = src_m;
            cmp_v  = src_m;
            mask_v = old_d;
         end
         BOP_INS_TRUE: begin
            pass_v = old_d;
            cmp_v  = old_d;
            mask_v = src_m;
         end
         default: begin
            pass_v = old_d;
            cmp_v  = old_d;
            mask_v = ~src_m;
         end
      endcase
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int LO = l * LANE_W;
      if (l < NARROW_LN) begin : g_low
         assign res[LO +: LANE_W] = pass_v[LO +: LANE_W]
            ^ ((cmp_v[LO +: LANE_W] ^ src_n[LO +: LANE_W]) & mask_v[LO +: LANE_W]);
      end else begin : g_high
         logic [LANE_W-1:0] merged;
         assign merged = pass_v[LO +: LANE_W]
            ^ ((cmp_v[LO +: LANE_W] ^ src_n[LO +: LANE_W]) & mask_v[LO +: LANE_W]);
         assign res[LO +: LANE_W] = wide ? merged : '0;
      end
   end

   always_comb begin
      if (!$isunknown({op, wide, src_n, src_m}) && op == BOP_XOR && wide) begin
         assert_xor_full_R2: assert (res == (src_n ^ src_m))
            else $error("xor result mismatch");
      end
   end
endmodule

// File: rtl/vbit_exec_unit.sv
`timescale 1ns/1ps
module vbit_exec_unit
   import vbit_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int NREG   = 32
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue_valid,
   output logic                issue_ready,
   input  logic [INSN_W-1:0]   issue_insn,
   output logic                wb_valid,
   output logic [RIDX_W-1:0]   wb_dst,
   output logic [DATA_W-1:0]   wb_data,
   output logic                illegal,
   input  logic [RIDX_W-1:0]   dbg_addr,
   output logic [DATA_W-1:0]   dbg_data
);
   localparam int HALF = DATA_W / 2;
   localparam int NRD  = 4;

   if (NREG != (1 << RIDX_W)) begin : g_bad_nreg
      $error("NREG must match the 5-bit register index");
   end
   if ((DATA_W % (2 * LANE_W)) != 0) begin : g_bad_width
      $error("DATA_W must be an even number of byte lanes");
   end

   bop_dec_t                   dec;
   logic                       fire;
   logic                       do_write;
   logic [NRD-1:0][DATA_W-1:0] rd_bus;
   logic [DATA_W-1:0]          result;

   assign issue_ready = 1'b1;
   assign fire        = issue_valid && issue_ready;
   assign do_write    = fire && dec.legal;

   vbit_decode u_dec (
      .insn (issue_insn),
      .dec  (dec)
   );

   vbit_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .raddr ({dbg_addr, dec.dst, dec.srcm, dec.srcn}),
      .rdata (rd_bus),
      .we    (do_write),
      .waddr (dec.dst),
      .wdata (result)
   );

   assign dbg_data = rd_bus[3];

   vbit_datapath #(.DATA_W(DATA_W)) u_dp (
      .op    (dec.op),
      .wide  (dec.wide),
      .src_n (rd_bus[0]),
      .src_m (rd_bus[1]),
      .old_d (rd_bus[2]),
      .res   (result)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         illegal  <= 1'b0;
         wb_dst   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= do_write;
         illegal  <= fire && !dec.legal;
         if (do_write) begin
            wb_dst  <= dec.dst;
            wb_data <= result;
         end
      end
   end

   assert_wb_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.legal) |=> (wb_valid && !illegal && wb_dst == $past(dec.dst)))
      else $error("legal issue without writeback");

   assert_illegal_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dec.legal) |=> (illegal && !wb_valid))
      else $error("illegal word handled wrongly");

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> (!wb_valid && !illegal))
      else $error("output pulse without issue");

   assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.legal && !dec.wide) |=> (wb_data[DATA_W-1:HALF] == '0))
      else $error("upper half not cleared");

   assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ready)
      else $error("ready dropped");
endmodule

// File: tb/vbit_exec_unit_tb_top.sv
`timescale 1ns/1ps
module vbit_exec_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_valid = 1'b0;
   logic         issue_ready;
   logic [31:0]  issue_insn = '0;
   logic         wb_valid;
   logic [4:0]   wb_dst;
   logic [127:0] wb_data;
   logic         illegal;
   logic [4:0]   dbg_addr = '0;
   logic [127:0] dbg_data;

   int total = 0;
   int bad = 0;
   bit checking = 1'b0;

   always #2.5 clk = ~clk;

   vbit_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_insn(issue_insn), .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
      .illegal(illegal), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
   );

   // ---------------- reference model ----------------
   logic [127:0] ref_rf [32];
   logic         exp_wb, exp_ill, exp_narrow;
   logic [4:0]   exp_dst;
   logic [127:0] exp_data;
   string        exp_tag;

   function automatic logic [127:0] seed_of(int idx);
      logic [127:0] v;
      for (int b = 0; b < 16; b++) v[b*8 +: 8] = 8'((idx * 29 + b * 7 + 3) % 256);
      return v;
   endfunction

   function automatic logic [127:0] model_op(logic [1:0] op, logic q,
                                              logic [127:0] n, logic [127:0] m, logic [127:0] d);
      logic [127:0] r;
      case (op)
         2'b00: r = n ^ m;                 // R2
         2'b01: r = (n & d) | (m & ~d);    // R3
         2'b10: r = (n & m) | (d & ~m);    // R4
         default: r = (n & ~m) | (d & m);  // R5
      endcase
      if (!q) r[127:64] = '0;              // R6
      return r;
   endfunction

   function automatic bit is_legal(logic [31:0] w);
      return w[31] == 1'b0 && w[29:24] == 6'b101110 && w[21] && w[15:10] == 6'b000111;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) ref_rf[i] <= seed_of(i);
         exp_wb <= 1'b0; exp_ill <= 1'b0; exp_narrow <= 1'b0;
         exp_dst <= '0; exp_data <= '0; exp_tag <= "R8";
      end else begin
         exp_wb <= 1'b0; exp_ill <= 1'b0;
         if (issue_valid) begin
            if (is_legal(issue_insn)) begin
               logic [4:0] rd, rn, rm;
               logic [127:0] r;
               rd = issue_insn[4:0]; rn = issue_insn[9:5]; rm = issue_insn[20:16];
               r = model_op(issue_insn[23:22], issue_insn[30], ref_rf[rn], ref_rf[rm], ref_rf[rd]);
               ref_rf[rd] <= r;
               exp_wb <= 1'b1; exp_dst <= rd; exp_data <= r; exp_narrow <= !issue_insn[30];
               if (rd == rn || rd == rm || rn == rm) exp_tag <= "R9";
               else case (issue_insn[23:22])
                  2'b00: exp_tag <= "R2";
                  2'b01: exp_tag <= "R3";
                  2'b10: exp_tag <= "R4";
                  default: exp_tag <= "R5";
               endcase
            end else begin
               exp_ill <= 1'b1;
            end
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison at the falling edge, one cycle after acceptance
   always @(negedge clk) begin
      if (checking) begin
         chk(wb_valid == exp_wb, "R7 wb_valid", 128'(wb_valid), 128'(exp_wb));
         chk(illegal == exp_ill, "R1 illegal", 128'(illegal), 128'(exp_ill));
         chk(issue_ready == 1'b1, "R7 ready", 128'(issue_ready), 128'd1);
         if (exp_wb) begin
            chk(wb_dst == exp_dst, "R7 wb_dst", 128'(wb_dst), 128'(exp_dst));
            chk(wb_data == exp_data, exp_tag, wb_data, exp_data);
            chk(dbg_data == ref_rf[dbg_addr], "R7 readback", dbg_data, ref_rf[dbg_addr]);
            if (exp_narrow) chk(wb_data[127:64] == '0, "R6 upper", wb_data, exp_data);
         end
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [31:0] mk(logic q, logic [1:0] op, logic [4:0] rm,
                                      logic [4:0] rn, logic [4:0] rd);
      return {1'b0, q, 6'b101110, op, 1'b1, rm, 6'b000111, rn, rd};
   endfunction

   task automatic send(logic [31:0] w);
      @(negedge clk);
      issue_valid = 1'b1;
      issue_insn  = w;
      dbg_addr    = w[4:0];
      @(negedge clk);
      issue_valid = 1'b0;
      issue_insn  = $urandom;
   endtask

   task automatic sweep(string tag);
      @(negedge clk);
      #0.2;
      for (int i = 0; i < 32; i++) begin
         dbg_addr = 5'(i);
         #0.01;
         chk(dbg_data == ref_rf[i], tag, dbg_data, ref_rf[i]);
      end
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      checking = 1'b1;
      // R8: reset contents and quiet outputs
      sweep("R8 reset contents");
      chk(!wb_valid && !illegal, "R8 outputs", 128'({wb_valid, illegal}), 128'd0);

      // R2..R6: each operation at both widths
      for (int op = 0; op < 4; op++) begin
         for (int q = 0; q < 2; q++) begin
            send(mk(1'(q), 2'(op), 5'(3 + op), 5'(10 + op), 5'(20 + op + 4 * q)));
         end
      end

      // R9: aliasing of destination and sources
      send(mk(1'b1, 2'b01, 5'd7, 5'd7, 5'd7));
      send(mk(1'b1, 2'b10, 5'd8, 5'd9, 5'd8));
      send(mk(1'b0, 2'b11, 5'd1, 5'd2, 5'd2));
      send(mk(1'b1, 2'b00, 5'd6, 5'd6, 5'd6));

      // R7: back-to-back dependent issues
      @(negedge clk);
      issue_valid = 1'b1; issue_insn = mk(1'b1, 2'b00, 5'd4, 5'd5, 5'd12);
      @(negedge clk);
      issue_insn = mk(1'b1, 2'b01, 5'd12, 5'd13, 5'd14);
      @(negedge clk);
      issue_valid = 1'b0;

      // R1: a bad fixed bit in each fixed field
      send(mk(1'b1, 2'b00, 5'd1, 5'd2, 5'd3) | 32'h8000_0000);
      send(mk(1'b1, 2'b00, 5'd1, 5'd2, 5'd3) ^ 32'h0100_0000);
      send(mk(1'b1, 2'b00, 5'd1, 5'd2, 5'd3) ^ 32'h0020_0000);
      send(mk(1'b1, 2'b00, 5'd1, 5'd2, 5'd3) ^ 32'h0000_0400);
      // R10: idle cycles with junk on the instruction bus
      repeat (5) @(negedge clk) issue_insn = mk(1'b1, 2'b00, 5'd0, 5'd0, 5'd0);
      sweep("R1/R10 no stray write");

      // random mix
      for (int k = 0; k < 800; k++) begin
         logic [31:0] w;
         int sel;
         w = mk(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
         sel = int'($urandom % 16);
         if (sel == 0) w[31] = 1'b1;
         else if (sel <= 6) w[23 + sel] = ~w[23 + sel];
         else if (sel == 7) w[21] = 1'b0;
         else if (sel == 8) w[10 + int'($urandom % 6)] ^= 1'b1;
         @(negedge clk);
         issue_valid = ($urandom % 5) != 0;
         issue_insn  = w;
         dbg_addr    = w[4:0];
      end
      @(negedge clk);
      issue_valid = 1'b0;
      sweep("R7 final contents");
      @(negedge clk);
      checking = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule